// File: doc/BRIEF.md
# Audio Codec Mixer Register File

This block is the control store of an audio codec mixer. It holds sixteen-bit registers for output and record volume, record source selection, power-down status, extended-audio control and five converter sample rates. A host reaches it through a one-cycle access port that carries an address, a write flag, an access size and write data. Read data comes back on the next clock.

Each register keeps only the bits it defines. Some registers are read-only. The three variable-rate converters can only be reprogrammed while their enable bit in the extended-control register is set. Clearing an enable bit forces the matching rates back to 48000. A write to address 0x00 reloads every default.

Whenever a stored rate is reloaded or rewritten, the block emits a one-cycle strobe. The strobe carries a per-channel mask and the new value, so a clock generator downstream can retune. The mute, volume and source fields are also decoded onto dedicated outputs for the datapath.

Top module: `mixer_regfile`

## Requirements
- R1: After reset the registers read as follows: address 0x00 reads 0x0000, master volume (0x02) reads 0x8000, PCM-out volume (0x18) reads 0x8808, record gain (0x1C) reads 0x8808, record select (0x1A) reads 0x0000, power-down (0x26) reads 0x000F, extended audio ID (0x28) reads 0x0809, extended control (0x2A) reads 0x0009, and the rates at 0x2C, 0x2E, 0x30, 0x32 and 0x34 read 0xBB80.
- R2: A write to master volume stores data AND 0xBF3F. A write to PCM-out volume stores data AND 0x9F1F. A write to record gain stores data AND 0x8F0F. Bit 15 of each of these registers is its mute bit.
- R3: Record select (0x1A) keeps only bits 2:0 (right source) and bits 10:8 (left source). Every other bit reads as zero.
- R4: A write to power-down (0x26) stores the written value with bit 15 and bits 3:0 cleared, ORed with the previous bits 3:0. Bits 3:0 are read-only status.
- R5: The rates at 0x2C (channel 0) and 0x32 (channel 3) accept writes only while extended-control bit 0 is 1. The rate at 0x34 (channel 4) accepts writes only while extended-control bit 3 is 1. The rates at 0x2E and 0x30 always accept writes.
- R6: A write to extended control stores the full value. If bit 0 of the written value is 0, rates 0x2C and 0x32 become 0xBB80. If bit 3 of the written value is 0, rate 0x34 becomes 0xBB80.
- R7: Writes to 0x7C (reads 0x8384), 0x7E (reads 0x7600) and 0x28 have no effect.
- R8: Any word write to 0x00 restores every register to its R1 value.
- R9: Every word address not named in R1 or R7 reads as zero and ignores writes.
- R10: Size codes are 0 for byte, 1 for word, 2 for dword and 3 for reserved. Only word accesses are valid. Any other read returns 0xFFFF, and any other write changes nothing.
- R11: One cycle after a rate is written or reloaded (R5, R6, R8), rate_chg pulses for one cycle. rate_chan bit i marks the rate at address 0x2C+2i, and rate_val carries the new value. A reload strobes even when the value is unchanged. A rejected write gives no strobe.
- R12: The decoded outputs follow the stored registers:
  - master: mute = bit 15, left = bits 13:8, right = bits 5:0
  - PCM: mute = bit 15, left = bits 12:8, right = bits 4:0
  - record gain: mute = bit 15, left = bits 11:8, right = bits 3:0
  - record sources: left = bits 10:8, right = bits 2:0
- R13: acc_rdata changes on the clock edge after a read access and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access strobe, one cycle per access |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0 byte, 1 word, 2 dword, 3 reserved |
| acc_addr | input | 8 | Byte address of the register |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Registered read data |
| rate_chg | output | 1 | One-cycle rate update strobe |
| rate_chan | output | 5 | Mask of the updated rate channels |
| rate_val | output | 16 | New rate value |
| mst_mute | output | 1 | Master mute |
| mst_left | output | 6 | Master left attenuation |
| mst_right | output | 6 | Master right attenuation |
| pcm_mute | output | 1 | PCM-out mute |
| pcm_left | output | 5 | PCM-out left attenuation |
| pcm_right | output | 5 | PCM-out right attenuation |
| rec_mute | output | 1 | Record mute |
| rec_left | output | 4 | Record left gain |
| rec_right | output | 4 | Record right gain |
| src_left | output | 3 | Left record source |
| src_right | output | 3 | Right record source |

## Verification
A wrong stored value shows up on the read port one cycle after the next word read. The volume and source fields also show it on the decoded outputs in the very cycle after the faulty write, with no read needed.

A broken rate gate or a broken reload shows up in two places. The strobe is missing or extra, or its mask is wrong, one cycle after the write. A later readback of the rate also returns the wrong value.

Interlock faults stay hidden until extended control is changed. For that reason the tests toggle each enable bit and then probe both the gated and the ungated rates.

// File: rtl/mixer_pkg.sv
package mixer_pkg;
    localparam int DW        = 16;
    localparam int AW        = 8;
    localparam int NUM_RATES = 5;

    localparam logic [AW-1:0] A_RESET   = 8'h00;
    localparam logic [AW-1:0] A_MASTER  = 8'h02;
    localparam logic [AW-1:0] A_PCM     = 8'h18;
    localparam logic [AW-1:0] A_RECSEL  = 8'h1A;
    localparam logic [AW-1:0] A_RECGAIN = 8'h1C;
    localparam logic [AW-1:0] A_PWRDN   = 8'h26;
    localparam logic [AW-1:0] A_EXTID   = 8'h28;
    localparam logic [AW-1:0] A_EXTCTL  = 8'h2A;
    localparam logic [AW-1:0] A_RATE0   = 8'h2C;
    localparam logic [AW-1:0] A_VEND1   = 8'h7C;
    localparam logic [AW-1:0] A_VEND2   = 8'h7E;

    localparam logic [DW-1:0] M_MASTER  = 16'hBF3F;
    localparam logic [DW-1:0] M_PCM     = 16'h9F1F;
    localparam logic [DW-1:0] M_RECGAIN = 16'h8F0F;
    localparam logic [DW-1:0] M_RECSEL  = 16'h0707;
    localparam logic [DW-1:0] M_PWR_RO  = 16'h000F;
    localparam logic [DW-1:0] M_PWR_DROP = 16'h800F;

    localparam logic [DW-1:0] D_MASTER  = 16'h8000;
    localparam logic [DW-1:0] D_PCM     = 16'h8808;
    localparam logic [DW-1:0] D_RECGAIN = 16'h8808;
    localparam logic [DW-1:0] D_PWRDN   = 16'h000F;
    localparam logic [DW-1:0] D_EXTID   = 16'h0809;
    localparam logic [DW-1:0] D_EXTCTL  = 16'h0009;
    localparam logic [DW-1:0] D_RATE    = 16'hBB80;
    localparam logic [DW-1:0] D_VEND1   = 16'h8384;
    localparam logic [DW-1:0] D_VEND2   = 16'h7600;

    localparam int VRA_BIT = 0;
    localparam int VRM_BIT = 3;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_RSVD  = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        GATE_NONE,
        GATE_VRA,
        GATE_VRM
    } rate_gate_e;

    function automatic rate_gate_e gate_of(input int idx);
        case (idx)
            0, 3:    return GATE_VRA;
            4:       return GATE_VRM;
            default: return GATE_NONE;
        endcase
    endfunction

    typedef struct packed {
        logic [DW-1:0] master;
        logic [DW-1:0] pcm;
        logic [DW-1:0] recgain;
        logic [DW-1:0] recsel;
        logic [DW-1:0] pwrdn;
        logic [DW-1:0] extctl;
    } ctrl_regs_t;

    localparam ctrl_regs_t CTRL_DEFAULTS = '{
        master:  D_MASTER,
        pcm:     D_PCM,
        recgain: D_RECGAIN,
        recsel:  '0,
        pwrdn:   D_PWRDN,
        extctl:  D_EXTCTL
    };
endpackage

// File: rtl/mixer_ctrl_regs.sv
module mixer_ctrl_regs
    import mixer_pkg::*;
#(
    parameter int DATA_W = DW,
    parameter int ADDR_W = AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_regs_t        regs,
    output logic              load_defaults,
    output logic              force_vra,
    output logic              force_vrm
);
    ctrl_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (addr)
                A_RESET:   regs_d = CTRL_DEFAULTS;
                A_MASTER:  regs_d.master  = wdata & M_MASTER;
                A_PCM:     regs_d.pcm     = wdata & M_PCM;
                A_RECGAIN: regs_d.recgain = wdata & M_RECGAIN;
                A_RECSEL:  regs_d.recsel  = wdata & M_RECSEL;
                A_PWRDN:   regs_d.pwrdn   = (wdata & ~M_PWR_DROP)
                                          | (regs_q.pwrdn & M_PWR_RO);
                A_EXTCTL:  regs_d.extctl  = wdata;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= CTRL_DEFAULTS;
        else        regs_q <= regs_d;
    end

    assign regs          = regs_q;
    assign load_defaults = wr_en && (addr == A_RESET);
    assign force_vra     = wr_en && (addr == A_EXTCTL) && !wdata[VRA_BIT];
    assign force_vrm     = wr_en && (addr == A_EXTCTL) && !wdata[VRM_BIT];

    // R2: master volume keeps only its defined bits
    p_master_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_MASTER) |=> regs_q.master == ($past(wdata) & M_MASTER));

    // R4: power-down status bits survive a write, bit 15 drops
    p_pwrdn_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_PWRDN) |=>
            (regs_q.pwrdn[3:0] == $past(regs_q.pwrdn[3:0])) && !regs_q.pwrdn[15]);
endmodule

// File: rtl/mixer_rate_bank.sv
module mixer_rate_bank
    import mixer_pkg::*;
#(
    parameter int DATA_W    = DW,
    parameter int ADDR_W    = AW,
    parameter int N_RATES   = NUM_RATES
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [DATA_W-1:0]               wdata,
    input  logic                            vra_en,
    input  logic                            vrm_en,
    input  logic                            load_defaults,
    input  logic                            force_vra,
    input  logic                            force_vrm,
    output logic [N_RATES-1:0][DATA_W-1:0]  rates,
    output logic                            rate_chg,
    output logic [N_RATES-1:0]              rate_chan,
    output logic [DATA_W-1:0]               rate_val
);
    typedef struct packed {
        logic [N_RATES-1:0][DATA_W-1:0] rate;
        logic                           chg;
        logic [N_RATES-1:0]             chan;
        logic [DATA_W-1:0]              val;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [N_RATES-1:0] hit;
    logic [N_RATES-1:0] reload;

    for (genvar gi = 0; gi < N_RATES; gi++) begin : g_chan
        localparam rate_gate_e GATE = gate_of(gi);
        localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(A_RATE0 + ADDR_W'(2 * gi));
        logic allow;
        if (GATE == GATE_VRA) begin : g_vra
            assign allow     = vra_en;
            assign reload[gi] = load_defaults || force_vra;
        end else if (GATE == GATE_VRM) begin : g_vrm
            assign allow     = vrm_en;
            assign reload[gi] = load_defaults || force_vrm;
        end else begin : g_free
            assign allow     = 1'b1;
            assign reload[gi] = load_defaults;
        end
        assign hit[gi] = wr_en && (addr == CH_ADDR) && allow;
    end

    always_comb begin
        bank_d      = bank_q;
        bank_d.chan = '0;
        for (int i = 0; i < N_RATES; i++) begin
            if (reload[i]) begin
                bank_d.rate[i] = D_RATE;
                bank_d.chan[i] = 1'b1;
                bank_d.val     = D_RATE;
            end else if (hit[i]) begin
                bank_d.rate[i] = wdata;
                bank_d.chan[i] = 1'b1;
                bank_d.val     = wdata;
            end
        end
        bank_d.chg = |bank_d.chan;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q.rate <= {N_RATES{D_RATE}};
            bank_q.chg  <= 1'b0;
            bank_q.chan <= '0;
            bank_q.val  <= D_RATE;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign rates     = bank_q.rate;
    assign rate_chg  = bank_q.chg;
    assign rate_chan = bank_q.chan;
    assign rate_val  = bank_q.val;

    // R5: a front-rate write with the variable-rate enable clear leaves it alone
    p_front_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_RATE0 && !vra_en && !load_defaults) |=>
            bank_q.rate[0] == $past(bank_q.rate[0]));

    // R6: clearing the enable bit returns the front rate to 48000
    p_force_default_r6: assert property (@(posedge clk) disable iff (!rst_n)
        force_vra |=> bank_q.rate[0] == D_RATE);

    // R11: a strobe for channel 0 carries the value now stored there
    p_strobe_value_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q.chg && bank_q.chan[0]) |-> bank_q.val == bank_q.rate[0]);
endmodule

// File: rtl/mixer_field_decode.sv
module mixer_field_decode
    import mixer_pkg::*;
(
    input  ctrl_regs_t  regs,
    output logic        mst_mute,
    output logic [5:0]  mst_left,
    output logic [5:0]  mst_right,
    output logic        pcm_mute,
    output logic [4:0]  pcm_left,
    output logic [4:0]  pcm_right,
    output logic        rec_mute,
    output logic [3:0]  rec_left,
    output logic [3:0]  rec_right,
    output logic [2:0]  src_left,
    output logic [2:0]  src_right
);
    always_comb begin
        mst_mute  = regs.master[15];
        mst_left  = regs.master[13:8];
        mst_right = regs.master[5:0];
        pcm_mute  = regs.pcm[15];
        pcm_left  = regs.pcm[12:8];
        pcm_right = regs.pcm[4:0];
        rec_mute  = regs.recgain[15];
        rec_left  = regs.recgain[11:8];
        rec_right = regs.recgain[3:0];
        src_left  = regs.recsel[10:8];
        src_right = regs.recsel[2:0];
    end
endmodule

// File: rtl/mixer_regfile.sv
module mixer_regfile
    import mixer_pkg::*;
#(
    parameter int DATA_W  = DW,
    parameter int ADDR_W  = AW,
    parameter int N_RATES = NUM_RATES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [1:0]         acc_size,
    input  logic [ADDR_W-1:0]  acc_addr,
    input  logic [DATA_W-1:0]  acc_wdata,
    output logic [DATA_W-1:0]  acc_rdata,
    output logic               rate_chg,
    output logic [N_RATES-1:0] rate_chan,
    output logic [DATA_W-1:0]  rate_val,
    output logic               mst_mute,
    output logic [5:0]         mst_left,
    output logic [5:0]         mst_right,
    output logic               pcm_mute,
    output logic [4:0]         pcm_left,
    output logic [4:0]         pcm_right,
    output logic               rec_mute,
    output logic [3:0]         rec_left,
    output logic [3:0]         rec_right,
    output logic [2:0]         src_left,
    output logic [2:0]         src_right
);
    localparam logic [DATA_W-1:0] ALL_ONES = '1;

    logic       is_word;
    logic       word_wr;
    ctrl_regs_t regs;
    logic       load_defaults, force_vra, force_vrm;
    logic [N_RATES-1:0][DATA_W-1:0] rates;
    logic [DATA_W-1:0] word_rd;
    logic [DATA_W-1:0] rdata_d, rdata_q;

    assign is_word = (acc_size == SZ_WORD);
    assign word_wr = acc_valid && acc_write && is_word;

    mixer_ctrl_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (word_wr),
        .addr          (acc_addr),
        .wdata         (acc_wdata),
        .regs          (regs),
        .load_defaults (load_defaults),
        .force_vra     (force_vra),
        .force_vrm     (force_vrm)
    );

    mixer_rate_bank #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .N_RATES(N_RATES)) u_rates (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (word_wr),
        .addr          (acc_addr),
        .wdata         (acc_wdata),
        .vra_en        (regs.extctl[VRA_BIT]),
        .vrm_en        (regs.extctl[VRM_BIT]),
        .load_defaults (load_defaults),
        .force_vra     (force_vra),
        .force_vrm     (force_vrm),
        .rates         (rates),
        .rate_chg      (rate_chg),
        .rate_chan     (rate_chan),
        .rate_val      (rate_val)
    );

    mixer_field_decode u_decode (
        .regs      (regs),
        .mst_mute  (mst_mute),
        .mst_left  (mst_left),
        .mst_right (mst_right),
        .pcm_mute  (pcm_mute),
        .pcm_left  (pcm_left),
        .pcm_right (pcm_right),
        .rec_mute  (rec_mute),
        .rec_left  (rec_left),
        .rec_right (rec_right),
        .src_left  (src_left),
        .src_right (src_right)
    );

    always_comb begin
        word_rd = '0;
        case (acc_addr)
            A_MASTER:  word_rd = regs.master;
            A_PCM:     word_rd = regs.pcm;
            A_RECGAIN: word_rd = regs.recgain;
            A_RECSEL:  word_rd = regs.recsel;
            A_PWRDN:   word_rd = regs.pwrdn;
            A_EXTID:   word_rd = D_EXTID;
            A_EXTCTL:  word_rd = regs.extctl;
            A_VEND1:   word_rd = D_VEND1;
            A_VEND2:   word_rd = D_VEND2;
            default:   ;
        endcase
        for (int i = 0; i < N_RATES; i++) begin
            if (acc_addr == ADDR_W'(A_RATE0 + ADDR_W'(2 * i))) word_rd = rates[i];
        end
    end

    always_comb begin
        rdata_d = rdata_q;
        if (acc_valid && !acc_write) rdata_d = is_word ? word_rd : ALL_ONES;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign acc_rdata = rdata_q;

    // R10: a read of any size other than word returns all ones
    p_nonword_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && !is_word) |=> acc_rdata == ALL_ONES);

    // R7: vendor identity reads back its fixed value
    p_vendor_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && is_word && acc_addr == A_VEND1) |=>
            acc_rdata == D_VEND1);

    // R13: read data holds while no read is issued
    p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_valid && !acc_write) |=> $stable(acc_rdata));
endmodule

// File: tb/mixer_regfile_bench.sv
module mixer_regfile_bench;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [1:0]  acc_size = 2'd1;
    logic [7:0]  acc_addr = '0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] acc_rdata;
    logic        rate_chg;
    logic [4:0]  rate_chan;
    logic [15:0] rate_val;
    logic        mst_mute, pcm_mute, rec_mute;
    logic [5:0]  mst_left, mst_right;
    logic [4:0]  pcm_left, pcm_right;
    logic [3:0]  rec_left, rec_right;
    logic [2:0]  src_left, src_right;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic        s_chg;
    logic [4:0]  s_chan;
    logic [15:0] s_val;

    always #(CLK_PERIOD / 2) clk = ~clk;

    mixer_regfile u_mixer_regfile (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_size(acc_size), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .rate_chg(rate_chg), .rate_chan(rate_chan),
        .rate_val(rate_val), .mst_mute(mst_mute), .mst_left(mst_left),
        .mst_right(mst_right), .pcm_mute(pcm_mute), .pcm_left(pcm_left),
        .pcm_right(pcm_right), .rec_mute(rec_mute), .rec_left(rec_left),
        .rec_right(rec_right), .src_left(src_left), .src_right(src_right)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [1:0] sz,
                          input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_size = sz; acc_addr = a; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        s_chg = rate_chg; s_chan = rate_chan; s_val = rate_val;
    endtask

    task automatic wr16(input logic [7:0] a, input logic [15:0] d);
        access(1'b1, 2'd1, a, d);
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input logic [15:0] exp);
        access(1'b0, 2'd1, a, 16'h0);
        check(tag, acc_rdata, exp);
    endtask

    task automatic t_reset_state;
        rd_check("R1 reset reg", 8'h00, 16'h0000);
        rd_check("R1 master", 8'h02, 16'h8000);
        rd_check("R1 pcm", 8'h18, 16'h8808);
        rd_check("R1 recgain", 8'h1C, 16'h8808);
        rd_check("R1 recsel", 8'h1A, 16'h0000);
        rd_check("R1 pwrdn", 8'h26, 16'h000F);
        rd_check("R1 extid", 8'h28, 16'h0809);
        rd_check("R1 extctl", 8'h2A, 16'h0009);
        for (int i = 0; i < 5; i++) rd_check("R1 rate", 8'(8'h2C + 2 * i), 16'hBB80);
        check("R12 reset master fields", {mst_mute, mst_left, mst_right}, {1'b1, 6'd0, 6'd0});
        check("R12 reset pcm fields", {pcm_mute, pcm_left, pcm_right}, {1'b1, 5'd8, 5'd8});
        check("R12 reset rec fields", {rec_mute, rec_left, rec_right}, {1'b1, 4'd8, 4'd8});
    endtask

    task automatic t_volumes;
        wr16(8'h02, 16'hFFFF);
        check("R12 master fields", {mst_mute, mst_left, mst_right}, {1'b1, 6'h3F, 6'h3F});
        rd_check("R2 master mask", 8'h02, 16'hBF3F);
        wr16(8'h18, 16'hFFFF);
        rd_check("R2 pcm mask", 8'h18, 16'h9F1F);
        wr16(8'h1C, 16'h7A35);
        rd_check("R2 recgain mask", 8'h1C, 16'h0A05);
        check("R12 rec fields", {rec_mute, rec_left, rec_right}, {1'b0, 4'hA, 4'h5});
        wr16(8'h02, 16'h1205);
        check("R12 master unmute", {mst_mute, mst_left, mst_right}, {1'b0, 6'h12, 6'h05});
    endtask

    task automatic t_recsel;
        wr16(8'h1A, 16'hFFFF);
        rd_check("R3 recsel all ones", 8'h1A, 16'h0707);
        wr16(8'h1A, 16'hF8F9);
        rd_check("R3 recsel pattern", 8'h1A, 16'h0001);
        check("R12 sources", {src_left, src_right}, {3'd0, 3'd1});
    endtask

    task automatic t_pwrdn;
        wr16(8'h26, 16'hFFF0);
        rd_check("R4 pwrdn set", 8'h26, 16'h7FFF);
        wr16(8'h26, 16'h0000);
        rd_check("R4 pwrdn clear", 8'h26, 16'h000F);
    endtask

    task automatic t_rates;
        wr16(8'h2C, 16'hAC44);
        check("R11 front strobe", {s_chg, s_chan, s_val}, {1'b1, 5'h01, 16'hAC44});
        @(negedge clk);
        check("R11 strobe one cycle", rate_chg, 1'b0);
        rd_check("R5 front accepted", 8'h2C, 16'hAC44);
        wr16(8'h34, 16'h1F40);
        check("R11 mic strobe", {s_chg, s_chan, s_val}, {1'b1, 5'h10, 16'h1F40});
        wr16(8'h32, 16'h5622);
        wr16(8'h2A, 16'h0008);
        check("R11 vra reload strobe", {s_chg, s_chan, s_val}, {1'b1, 5'h09, 16'hBB80});
        rd_check("R6 front forced", 8'h2C, 16'hBB80);
        rd_check("R6 lr forced", 8'h32, 16'hBB80);
        rd_check("R6 mic kept", 8'h34, 16'h1F40);
        rd_check("R6 extctl stored", 8'h2A, 16'h0008);
        wr16(8'h2C, 16'h5622);
        check("R11 no strobe on reject", s_chg, 1'b0);
        rd_check("R5 front rejected", 8'h2C, 16'hBB80);
        wr16(8'h32, 16'h5622);
        rd_check("R5 lr rejected", 8'h32, 16'hBB80);
        wr16(8'h2E, 16'h7D00);
        check("R11 surround strobe", {s_chg, s_chan}, {1'b1, 5'h02});
        rd_check("R5 surround free", 8'h2E, 16'h7D00);
        wr16(8'h2A, 16'h0000);
        check("R11 both reload strobe", {s_chg, s_chan}, {1'b1, 5'h19});
        rd_check("R6 mic forced", 8'h34, 16'hBB80);
        wr16(8'h34, 16'h1234);
        rd_check("R5 mic rejected", 8'h34, 16'hBB80);
        wr16(8'h30, 16'h2B11);
        rd_check("R5 lfe free", 8'h30, 16'h2B11);
    endtask

    task automatic t_read_only;
        wr16(8'h7C, 16'h0000);
        wr16(8'h7E, 16'hFFFF);
        wr16(8'h28, 16'h0000);
        rd_check("R7 vendor1", 8'h7C, 16'h8384);
        rd_check("R7 vendor2", 8'h7E, 16'h7600);
        rd_check("R7 extid", 8'h28, 16'h0809);
    endtask

    task automatic t_unlisted;
        wr16(8'h04, 16'hFFFF);
        rd_check("R9 headphone", 8'h04, 16'h0000);
        wr16(8'h22, 16'h1234);
        rd_check("R9 3d", 8'h22, 16'h0000);
        wr16(8'h40, 16'hBEEF);
        rd_check("R9 unmapped", 8'h40, 16'h0000);
    endtask

    task automatic t_sizes;
        access(1'b0, 2'd0, 8'h02, 16'h0);
        check("R10 byte read", acc_rdata, 16'hFFFF);
        access(1'b0, 2'd2, 8'h02, 16'h0);
        check("R10 dword read", acc_rdata, 16'hFFFF);
        access(1'b1, 2'd2, 8'h02, 16'h0000);
        access(1'b1, 2'd0, 8'h2E, 16'h0001);
        check("R10 dropped write no strobe", s_chg, 1'b0);
        rd_check("R10 master kept", 8'h02, 16'h1205);
        rd_check("R10 surround kept", 8'h2E, 16'h7D00);
        access(1'b1, 2'd3, 8'h00, 16'h0);
        rd_check("R10 reserved size no reload", 8'h02, 16'h1205);
    endtask

    task automatic t_latency;
        rd_check("R13 read", 8'h1A, 16'h0001);
        wr16(8'h1A, 16'h0303);
        @(negedge clk);
        check("R13 hold after write", acc_rdata, 16'h0001);
    endtask

    task automatic t_reload;
        wr16(8'h00, 16'h5A5A);
        check("R11 reload strobe", {s_chg, s_chan, s_val}, {1'b1, 5'h1F, 16'hBB80});
        rd_check("R8 master", 8'h02, 16'h8000);
        rd_check("R8 recsel", 8'h1A, 16'h0000);
        rd_check("R8 extctl", 8'h2A, 16'h0009);
        rd_check("R8 surround", 8'h2E, 16'hBB80);
        rd_check("R8 lfe", 8'h30, 16'hBB80);
        rd_check("R8 pwrdn", 8'h26, 16'h000F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 idle after reset", rate_chg, 1'b0);
        t_reset_state();
        t_volumes();
        t_recsel();
        t_pwrdn();
        t_rates();
        t_read_only();
        t_unlisted();
        t_sizes();
        t_latency();
        t_reload();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule